// File: doc/BRIEF.md
# Fractional Audio Word-Clock Generator

This block derives the sample-rate word clock of an audio serial port from an internal prescaled clock when the port is the clock master. A programmable 16-bit step value is added to a phase accumulator on every prescaled-clock cycle. Each carry out of the accumulator is one oversample event. A modulo counter turns these events into a word clock with 50% duty and one single-cycle sample tick per audio frame. The oversample ratio is 96 in the low-rate mode and 48 in the high-rate mode.

The step value is computed by software as `step = 65536 * R * f_word / f_clk`. Here R is 96 when `hi_rate` is 0 and 48 when it is 1, and f_clk is the prescaled clock. For example, a prescaled clock of 11.2896 MHz with an 8 kHz frame rate in the low-rate mode gives 0x116A. The step value does not need to divide the clock evenly, because the accumulator carries the fractional remainder from one event to the next. `hi_rate` should be set for frame rates above 50 kHz. Any change of either input restarts the phase, so the new rate begins with a whole period.

Top module: `wclk_nco`

## Requirements
- R1: While `rst_n` is low, `word_clk` and `sample_tick` are 0.
- R2: With `hi_rate` = 0 and a nonzero `step` for which 96*65536/step is an integer N, `sample_tick` pulses once every N clock cycles.
- R3: With `hi_rate` = 1 and a nonzero `step` for which 48*65536/step is an integer N, `sample_tick` pulses once every N clock cycles.
- R4: Between two sample ticks, `word_clk` is 1 for exactly N/2 cycles. It goes high after half of the 96 (or 48) accumulator carries of a frame and low on the last carry.
- R5: `sample_tick` is high for one cycle at a time. It is high in the cycle where `word_clk` has just fallen: `word_clk` is 0 in that cycle and was 1 in the cycle before.
- R6: While `step` is 0, `word_clk` stays 0 and `sample_tick` never pulses.
- R7: A clock edge that sees `step` or `hi_rate` differ from the value held at the previous edge clears the phase. `word_clk` and `sample_tick` are 0 after that edge, and the first tick is set by the edge N cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaled clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step | input | 16 | Phase increment per clock cycle |
| hi_rate | input | 1 | 1 selects 48x oversampling, 0 selects 96x |
| word_clk | output | 1 | Frame-rate clock with 50% duty |
| sample_tick | output | 1 | One-cycle pulse at each frame boundary |

## Verification
Every output is registered, so a change in the inputs first shows up after the next rising edge. The bench drives inputs and samples outputs at falling edges. After a configuration change, the first tick is therefore due at the (N+1)-th falling edge. The bench counts falling edges from the moment it drives the inputs and compares the count with N+1, which it computes from the step value and the mode. The steady-state period and the high time are measured from one tick to the next, so they do not depend on where the restart happened.

// File: rtl/wclk_nco.sv
module wclk_nco #(
  parameter int ACC_W  = 16,
  parameter int LO_OSR = 96,
  parameter int HI_OSR = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] step,
  input  logic             hi_rate,
  output logic             word_clk,
  output logic             sample_tick
);
  localparam int MAX_OSR = (LO_OSR > HI_OSR) ? LO_OSR : HI_OSR;
  localparam int CNT_W   = $clog2(MAX_OSR);

  logic [ACC_W-1:0] acc, step_q;
  logic             hi_q;
  logic [CNT_W-1:0] cnt, cnt_nxt, last, half;
  logic [ACC_W:0]   sum;
  logic             carry, cfg_chg, wrap;

  assign sum     = {1'b0, acc} + {1'b0, step};
  assign carry   = sum[ACC_W];
  assign cfg_chg = (step != step_q) || (hi_rate != hi_q);
  assign last    = hi_rate ? CNT_W'(HI_OSR - 1) : CNT_W'(LO_OSR - 1);
  assign half    = hi_rate ? CNT_W'(HI_OSR / 2) : CNT_W'(LO_OSR / 2);
  assign wrap    = carry && (cnt == last);
  assign cnt_nxt = wrap ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc         <= '0;
      step_q      <= '0;
      hi_q        <= 1'b0;
      cnt         <= '0;
      word_clk    <= 1'b0;
      sample_tick <= 1'b0;
    end else begin
      step_q      <= step;
      hi_q        <= hi_rate;
      sample_tick <= 1'b0;
      if (cfg_chg) begin
        acc      <= '0;
        cnt      <= '0;
        word_clk <= 1'b0;
      end else begin
        acc <= sum[ACC_W-1:0];
        if (carry) begin
          cnt         <= cnt_nxt;
          word_clk    <= (cnt_nxt >= half);
          sample_tick <= wrap;
        end
      end
    end
  end
endmodule

// File: rtl/wclk_nco_chk.sv
module wclk_nco_chk #(
  parameter int ACC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ACC_W-1:0] step,
  input logic             hi_rate,
  input logic             word_clk,
  input logic             sample_tick
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!word_clk && !sample_tick));

  assert_tick_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> (!word_clk && $past(word_clk)));

  assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick);

  assert_zero_step_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step == '0 && $past(step) == '0) |-> (!word_clk && !sample_tick));

  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step != $past(step) || hi_rate != $past(hi_rate)) |=> (!word_clk && !sample_tick));
endmodule

bind wclk_nco wclk_nco_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .hi_rate(hi_rate),
  .word_clk(word_clk), .sample_tick(sample_tick)
);

// File: tb/wclk_nco_tb.sv
`timescale 1ns/1ps
module wclk_nco_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] step = '0;
  logic        hi_rate = 1'b0;
  logic        word_clk, sample_tick;
  int          n_run = 0, n_fail = 0;
  int          cyc = 0;

  always #2.5 clk = ~clk;

  wclk_nco u_dut (
    .clk(clk), .rst_n(rst_n), .step(step), .hi_rate(hi_rate),
    .word_clk(word_clk), .sample_tick(sample_tick)
  );

  localparam int NV = 7;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 16'h8000}, {1'b1, 16'h8000}, {1'b0, 16'h4000}, {1'b1, 16'h4000},
    {1'b0, 16'h6000}, {1'b1, 16'h6000}, {1'b0, 16'hC000}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish, got %0d cycles, expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_run = n_run + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int frame_len(input logic [15:0] s, input logic h);
    return (h ? 48 : 96) * 65536 / int'(s);
  endfunction

  task automatic wait_tick(output int n);
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      n++;
      if (sample_tick) return;
    end
  endtask

  task automatic measure(output int per, output int hi, output int fall_ok);
    int prev;
    int dummy;
    per = 0; hi = 0; fall_ok = 1;
    wait_tick(dummy);
    prev = word_clk;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      per++;
      if (word_clk) hi++;
      if (sample_tick) begin
        if (word_clk || !prev) fall_ok = 0;
        @(negedge clk);
        if (sample_tick) fall_ok = 0;
        return;
      end
      prev = word_clk;
    end
  endtask

  initial begin
    int per, hi, ok, n, seen;
    repeat (3) @(negedge clk);
    check("R1 word_clk in reset", int'(word_clk), 0);
    check("R1 sample_tick in reset", int'(sample_tick), 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      step = VEC[v][15:0];
      hi_rate = VEC[v][16];
      measure(per, hi, ok);
      if (hi_rate) check("R3 period hi-rate", per, frame_len(step, hi_rate));
      else         check("R2 period lo-rate", per, frame_len(step, hi_rate));
      check("R4 high time", hi, frame_len(step, hi_rate) / 2);
      check("R5 tick single and on fall", ok, 1);
    end

    step = 16'h4000; hi_rate = 1'b1;
    repeat (50) @(negedge clk);
    step = 16'h8000; hi_rate = 1'b0;
    wait_tick(n);
    check("R7 first tick after step change", n, frame_len(16'h8000, 1'b0) + 1);

    repeat (30) @(negedge clk);
    hi_rate = 1'b1;
    @(negedge clk);
    check("R7 cleared after mode change", int'(word_clk), 0);
    n = 1;
    if (!sample_tick) begin
      wait_tick(n);
      n = n + 1;
    end
    check("R7 first tick after mode change", n, frame_len(16'h8000, 1'b1) + 1);

    repeat (60) @(negedge clk);
    step = 16'h0000;
    seen = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (sample_tick || word_clk) seen++;
    end
    check("R6 zero step idle", seen, 0);

    step = 16'hC000; hi_rate = 1'b0;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 word_clk after mid-run reset", int'(word_clk), 0);
    rst_n = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule